// File: doc/BRIEF.md
# PHY Test-Port Register Access Sequencer

This block sits between a host that wants to read or write 8-bit registers inside a PHY and the PHY's narrow test port. That port has five pins: a test clock, a test enable, a test clear, an 8-bit input bus and an 8-bit output bus. A host request is a register address, write data and an operation selector: read, write or clear. The sequencer turns each request into the pin-level strobe pattern the port expects. When the pattern ends it returns one response cycle that carries read data and an error flag.

A register access always opens with an address phase. The address is driven with enable high and clocked in by one full test-clock pulse. A write then lowers enable, drives the data and gives a second pulse. A read instead leaves enable low and waits a programmable number of system clocks so the port output can settle. It then samples the output bus. A clear operation pulses the test-clear pin and leaves the other pins idle. Each test-clock level lasts a programmable number of system clocks. The request wires are wider than 8 bits so that out-of-range values can be detected and refused.

The request side is a valid/ready stream with no internal queue. The block accepts a request only in a cycle where `req_valid` and `req_ready` are both high. It lowers `req_ready` for the whole sequence, so the host must hold its request until it is taken. The response side has no back-pressure: `rsp_valid` is a single-cycle strobe that the host must capture when it occurs.

Top module: `phy_tport_seq`

## Requirements
- R1: During and directly after reset, `req_ready` is 1 and `tst_clk`, `tst_en`, `tst_clr`, `tst_din` and `rsp_valid` are all 0.
- R2: A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the cycle in which `rsp_valid` is 1. Requests presented while `req_ready` is 0 are ignored and alter no PHY register.
- R3: A write is selected by `req_clear`=0 and `req_write`=1. The pin sequence has three parts. First, enable goes high, the address is driven on `tst_din` and one test-clock pulse is given. Second, enable goes low and the data is driven. Third, a second test-clock pulse is given. `rsp_valid` rises 6·P cycles after acceptance, where P is `cfg_phase_cycles` with 0 treated as 1.
- R4: A read is selected by `req_clear`=0 and `req_write`=0. It performs the same address phase as a write and then holds enable low for S cycles, where S is `cfg_settle_cycles` with 0 treated as 1. It then samples `tst_dout` into `rsp_rdata`. `rsp_valid` rises 3·P+S cycles after acceptance.
- R5: `tst_din` is unchanged in the system-clock cycle in which `tst_clk` rises and in the cycle in which it falls. This gives one full phase of setup before each rising edge and one full phase of hold after it.
- R6: Every high level of `tst_clk` lasts exactly P system clocks, and every low phase inside a sequence lasts P clocks as well.
- R7: `req_clear`=1 selects clear and takes priority over `req_write`. `tst_clr` goes from low to high for P cycles and then back to low. `tst_clk` and `tst_en` stay low during the clear. `rsp_valid` rises 2·P cycles after acceptance with `rsp_err`=0.
- R8: A read or write whose address exceeds 0xFF is refused, and so is a write whose data exceeds 0xFF. The refusal answers 1 cycle after acceptance with `rsp_err`=1, no `tst_clk` pulse and no PHY register changed. The data value of a read is not checked.
- R9: `rsp_valid` is high for exactly one cycle per accepted request. On that cycle `rsp_err` is 0 for every accepted, non-refused request. `rsp_rdata` is 0 for any response that is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_phase_cycles | input | CW (16) | System clocks per test-clock level (0 treated as 1) |
| cfg_settle_cycles | input | CW (16) | Read settle wait in system clocks (0 treated as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_clear | input | 1 | 1 selects a clear operation |
| req_write | input | 1 | 1 selects write, 0 selects read (when not clear) |
| req_addr | input | REQ_W (16) | Register address; values above 0xFF are refused |
| req_wdata | input | REQ_W (16) | Write data; values above 0xFF are refused on writes |
| rsp_valid | output | 1 | Single-cycle completion strobe |
| rsp_rdata | output | PW (8) | Read data; 0 for other operations |
| rsp_err | output | 1 | Request was refused as out of range |
| tst_clk | output | 1 | Test-port clock |
| tst_en | output | 1 | Test-port enable (high marks the address phase) |
| tst_clr | output | 1 | Test-port clear |
| tst_din | output | PW (8) | Test-port address/data bus |
| tst_dout | input | PW (8) | Test-port read-back bus |

## Verification
The assertions assume two things about the inputs. First, the host never changes the configuration inputs while a sequence is running. Second, the PHY drives a valid `tst_dout` within the configured settle window after the address strobe. The stimulus changes the phase and settle counts only while `req_ready` is high. The register-file stub in the bench presents valid read-back data only after a fixed delay from its address latch, and the settle counts are picked so that this delay always fits inside the read window. Random requests mix valid reads and writes, clears, out-of-range requests and requests poked at a busy block. Directed cases cover zero phase and settle counts and the extreme addresses.

// File: rtl/tport_pkg.sv
package tport_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_A_SET,
    ST_A_HI,
    ST_A_LO,
    ST_D_SET,
    ST_D_HI,
    ST_D_LO,
    ST_SETTLE,
    ST_CLR_HI,
    ST_CLR_LO,
    ST_ERR
  } tp_state_e;

  typedef enum logic [1:0] {
    TP_OP_READ  = 2'd0,
    TP_OP_WRITE = 2'd1,
    TP_OP_CLEAR = 2'd2
  } tp_op_e;

endpackage

// File: rtl/tport_range_check.sv
module tport_range_check
  import tport_pkg::*;
#(
  parameter int REQ_W = 16,
  parameter int PW    = 8
) (
  input  tp_op_e           op,
  input  logic [REQ_W-1:0] addr,
  input  logic [REQ_W-1:0] wdata,
  output logic             bad
);

  localparam logic [REQ_W-1:0] LIMIT = REQ_W'((64'd1 << PW) - 64'd1);

  logic addr_over;
  logic data_over;

  assign addr_over = (addr > LIMIT);
  assign data_over = (wdata > LIMIT);

  // clear never refused; read ignores the data field
  assign bad = (op != TP_OP_CLEAR) &&
               (addr_over || ((op == TP_OP_WRITE) && data_over));

endmodule

// File: rtl/tport_phase_timer.sv
module tport_phase_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expire
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  // a zero limit behaves as a one-cycle interval
  assign last   = (limit == '0) ? '0 : limit - 1'b1;
  assign expire = (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (!expire) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tport_seq_fsm.sv
module tport_seq_fsm
  import tport_pkg::*;
#(
  parameter int PW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  tp_op_e        start_op,
  input  logic          start_bad,
  input  logic [PW-1:0] start_addr,
  input  logic [PW-1:0] start_data,
  input  logic [CW-1:0] phase_cycles,
  input  logic [CW-1:0] settle_cycles,
  input  logic [PW-1:0] tst_dout,
  output logic          busy,
  output logic          tst_clk,
  output logic          tst_en,
  output logic          tst_clr,
  output logic [PW-1:0] tst_din,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_rdata,
  output logic          rsp_err
);

  tp_state_e     state, state_nx;
  logic [PW-1:0] addr_q, data_q;
  logic          wr_q;
  logic          step;
  logic          expire;
  logic          finish;
  logic [CW-1:0] tlimit;

  assign tlimit = (state == ST_SETTLE) ? settle_cycles : phase_cycles;

  tport_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (step || (state == ST_IDLE)),
    .limit   (tlimit),
    .expire  (expire)
  );

  always_comb begin
    case (state)
      ST_IDLE: step = start;
      ST_ERR:  step = 1'b1;
      default: step = expire;
    endcase
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: begin
        if (start_bad)                    state_nx = ST_ERR;
        else if (start_op == TP_OP_CLEAR) state_nx = ST_CLR_HI;
        else                              state_nx = ST_A_SET;
      end
      ST_A_SET:  state_nx = ST_A_HI;
      ST_A_HI:   state_nx = ST_A_LO;
      ST_A_LO:   state_nx = wr_q ? ST_D_SET : ST_SETTLE;
      ST_D_SET:  state_nx = ST_D_HI;
      ST_D_HI:   state_nx = ST_D_LO;
      ST_D_LO:   state_nx = ST_IDLE;
      ST_SETTLE: state_nx = ST_IDLE;
      ST_CLR_HI: state_nx = ST_CLR_LO;
      ST_CLR_LO: state_nx = ST_IDLE;
      ST_ERR:    state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  assign finish = step && (state != ST_IDLE) && (state_nx == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      data_q    <= '0;
      wr_q      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      if (step) state <= state_nx;
      if (start && (state == ST_IDLE)) begin
        addr_q <= start_addr;
        data_q <= start_data;
        wr_q   <= (start_op == TP_OP_WRITE);
      end
      rsp_valid <= finish;
      if (finish) begin
        rsp_err   <= (state == ST_ERR);
        rsp_rdata <= (state == ST_SETTLE) ? tst_dout : '0;
      end
    end
  end

  assign busy    = (state != ST_IDLE);
  assign tst_clk = (state == ST_A_HI) || (state == ST_D_HI);
  assign tst_en  = (state == ST_A_SET) || (state == ST_A_HI) || (state == ST_A_LO);
  assign tst_clr = (state == ST_CLR_HI);

  always_comb begin
    case (state)
      ST_A_SET, ST_A_HI, ST_A_LO, ST_SETTLE: tst_din = addr_q;
      ST_D_SET, ST_D_HI, ST_D_LO:            tst_din = data_q;
      default:                               tst_din = '0;
    endcase
  end

  // R2: an accepted request makes the block busy on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R5: bus held across the rising edge of the test clock
  a_r5_din_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tst_clk) |-> $stable(tst_din));

  // R5: bus held until the test clock falls again
  a_r5_din_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tst_clk) |-> $stable(tst_din));

  // R7: clear pulse never overlaps a clock or enable strobe
  a_r7_clr_alone: assert property (@(posedge clk) disable iff (!rst_n)
    tst_clr |-> (!tst_clk && !tst_en));

  // R9: completion strobe lasts a single cycle
  a_r9_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: a refused request ends with the port idle
  a_r8_err_port_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (!tst_clk && !tst_en && !tst_clr));

endmodule

// File: rtl/phy_tport_seq.sv
module phy_tport_seq
  import tport_pkg::*;
#(
  parameter int REQ_W = 16,
  parameter int PW    = 8,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_phase_cycles,
  input  logic [CW-1:0]    cfg_settle_cycles,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_clear,
  input  logic             req_write,
  input  logic [REQ_W-1:0] req_addr,
  input  logic [REQ_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [PW-1:0]    rsp_rdata,
  output logic             rsp_err,
  output logic             tst_clk,
  output logic             tst_en,
  output logic             tst_clr,
  output logic [PW-1:0]    tst_din,
  input  logic [PW-1:0]    tst_dout
);

  tp_op_e op;
  logic   bad;
  logic   busy;
  logic   accept;

  assign op = req_clear ? TP_OP_CLEAR : (req_write ? TP_OP_WRITE : TP_OP_READ);

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  tport_range_check #(.REQ_W(REQ_W), .PW(PW)) u_range (
    .op    (op),
    .addr  (req_addr),
    .wdata (req_wdata),
    .bad   (bad)
  );

  tport_seq_fsm #(.PW(PW), .CW(CW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept),
    .start_op      (op),
    .start_bad     (bad),
    .start_addr    (req_addr[PW-1:0]),
    .start_data    (req_wdata[PW-1:0]),
    .phase_cycles  (cfg_phase_cycles),
    .settle_cycles (cfg_settle_cycles),
    .tst_dout      (tst_dout),
    .busy          (busy),
    .tst_clk       (tst_clk),
    .tst_en        (tst_en),
    .tst_clr       (tst_clr),
    .tst_din       (tst_din),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_err       (rsp_err)
  );

  // R2: requests offered while busy are not taken
  a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (!req_ready || rsp_valid));

endmodule

// File: tb/tb_phy_tport_seq.sv
module tb_phy_tport_seq;

  localparam int CLK_PERIOD = 10;
  localparam int STUB_LAT   = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_phase_cycles, cfg_settle_cycles;
  logic        req_valid, req_clear, req_write;
  logic        req_ready;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_valid, rsp_err;
  logic [7:0]  rsp_rdata;
  logic        tst_clk, tst_en, tst_clr;
  logic [7:0]  tst_din, tst_dout;

  int n_vec  = 0;
  int n_fail = 0;
  int ph_g   = 1;
  int rise_cnt = 0;
  bit done_flag = 0;
  logic [7:0] exp_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_tport_seq dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_phase_cycles(cfg_phase_cycles), .cfg_settle_cycles(cfg_settle_cycles),
    .req_valid(req_valid), .req_ready(req_ready), .req_clear(req_clear),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tst_clk(tst_clk), .tst_en(tst_en), .tst_clr(tst_clr),
    .tst_din(tst_din), .tst_dout(tst_dout)
  );

  // PHY register-file stub: latches address on a test-clock rise with enable high,
  // writes on a rise with enable low, read-back valid STUB_LAT clocks after latch
  logic [7:0] mem [256];
  logic [7:0] s_addr;
  int         s_age;
  logic       s_pclk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      s_addr <= 8'h00;
      s_age  <= 0;
      s_pclk <= 1'b0;
    end else begin
      s_pclk <= tst_clk;
      if (tst_clr) begin
        for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      end else if (tst_clk && !s_pclk) begin
        if (tst_en) begin
          s_addr <= tst_din;
          s_age  <= 0;
        end else begin
          mem[s_addr] <= tst_din;
        end
      end else if (s_age < 1000) begin
        s_age <= s_age + 1;
      end
    end
  end

  assign tst_dout = (s_age >= STUB_LAT) ? mem[s_addr] : 8'hEE;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // pin monitor: R5 bus stability, R6 high-phase length, R7 clear length
  logic       p_clk, p_clr;
  logic [7:0] p_din;
  int         hi_len, clr_len;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_clk = 1'b0; p_clr = 1'b0; p_din = 8'h00; hi_len = 0; clr_len = 0;
    end else begin
      if (tst_clk && !p_clk) begin
        rise_cnt++;
        hi_len = 1;
        chk(tst_din == p_din, "R5", "din changed at rise", tst_din, p_din);
      end else if (tst_clk) begin
        hi_len++;
      end
      if (!tst_clk && p_clk) begin
        chk(tst_din == p_din, "R5", "din changed at fall", tst_din, p_din);
        chk(hi_len == ph_g, "R6", "test clock high length", hi_len, ph_g);
      end
      if (tst_clr) clr_len = p_clr ? clr_len + 1 : 1;
      if (!tst_clr && p_clr)
        chk(clr_len == ph_g, "R7", "clear pulse length", clr_len, ph_g);
      p_clk = tst_clk; p_clr = tst_clr; p_din = tst_din;
    end
  end

  task automatic set_cfg(input int p, input int s);
    @(negedge clk);
    cfg_phase_cycles  = 16'(p);
    cfg_settle_cycles = 16'(s);
    ph_g = (p == 0) ? 1 : p;
  endtask

  function automatic int exp_latency(input bit bad, input bit clr, input bit wr,
                                     input int p, input int s);
    if (bad) return 1;
    if (clr) return 2 * p;
    if (wr)  return 6 * p;
    return 3 * p + s;
  endfunction

  task automatic run_op(input bit clr, input bit wr, input logic [15:0] a,
                        input logic [15:0] d, input bit poke);
    bit bad;
    int p, s, lat, erise, n;
    bit fin;
    logic [7:0] erd;
    string rq;
    bad = !clr && ((a > 16'h00FF) || (wr && (d > 16'h00FF)));
    p = (cfg_phase_cycles == 0) ? 1 : int'(cfg_phase_cycles);
    s = (cfg_settle_cycles == 0) ? 1 : int'(cfg_settle_cycles);
    lat = exp_latency(bad, clr, wr, p, s);
    rq = bad ? "R8" : (clr ? "R7" : (wr ? "R3" : "R4"));
    erise = (bad || clr) ? 0 : (wr ? 2 : 1);
    erd = (!bad && !clr && !wr) ? exp_mem[a[7:0]] : 8'h00;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_clear = clr; req_write = wr; req_addr = a; req_wdata = d;
    rise_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    if (poke) begin
      chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
      req_clear = 1'b0; req_write = 1'b1;
      req_addr = {8'h00, a[7:0] ^ 8'h5A}; req_wdata = 16'h00C3;
    end else begin
      req_valid = 1'b0;
    end
    n = 0; fin = 0;
    while (!fin) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      if (rsp_valid || n > 20000) fin = 1;
    end
    chk(n == lat, rq, "response latency", n, lat);
    chk(rsp_err == bad, bad ? "R8" : "R9", "error flag", rsp_err, bad);
    chk(rsp_rdata == erd, wr || clr || bad ? "R9" : "R4", "read data", rsp_rdata, erd);
    chk(rise_cnt == erise, rq, "test clock pulses", rise_cnt, erise);
    chk(req_ready == 1'b1, "R2", "ready at response", req_ready, 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9", "response strobe width", rsp_valid, 0);
    if (!bad) begin
      if (clr) for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
      else if (wr) exp_mem[a[7:0]] = d[7:0];
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    rst_n = 1'b0;
    req_valid = 0; req_clear = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    cfg_phase_cycles = 16'd1; cfg_settle_cycles = 16'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1 && tst_clk == 0 && tst_en == 0 && tst_clr == 0 &&
        tst_din == 0 && rsp_valid == 0, "R1", "outputs in reset",
        {req_ready, tst_clk, tst_en, tst_clr, rsp_valid}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1 && tst_clk == 0 && tst_en == 0 && tst_clr == 0 &&
        tst_din == 0 && rsp_valid == 0, "R1", "outputs after reset",
        {req_ready, tst_clk, tst_en, tst_clr, rsp_valid}, 5'b10000);

    // directed corners
    set_cfg(1, 2);
    run_op(0, 1, 16'h0010, 16'h00AB, 0);   // R3
    run_op(0, 0, 16'h0010, 16'h0000, 0);   // R4
    set_cfg(3, 5);
    run_op(0, 1, 16'h00FF, 16'h0001, 0);   // R3 top address
    run_op(0, 0, 16'h00FF, 16'h0000, 0);   // R4
    run_op(0, 0, 16'h0000, 16'h0000, 0);   // R4 bottom address
    set_cfg(0, 4);                         // R6 zero phase treated as one
    run_op(0, 1, 16'h0033, 16'h005C, 0);
    run_op(0, 0, 16'h0033, 16'h0000, 0);
    set_cfg(2, 0);                         // R4 zero settle treated as one
    run_op(0, 0, 16'h0033, 16'h0000, 0);
    set_cfg(1, 3);
    run_op(0, 0, 16'h0100, 16'h0000, 0);   // R8 address out of range
    run_op(0, 1, 16'h0012, 16'h01FF, 0);   // R8 data out of range
    run_op(0, 0, 16'h0012, 16'h0000, 0);   // R8 register untouched
    run_op(0, 0, 16'h0012, 16'h01FF, 0);   // R8 read data not checked
    run_op(0, 1, 16'h0020, 16'h0077, 1);   // R2 poke while busy
    run_op(0, 0, 16'h007A, 16'h0000, 0);   // R2 poked write ignored
    set_cfg(2, 3);
    run_op(1, 1, 16'h0000, 16'h0000, 0);   // R7 clear wins over write
    run_op(0, 0, 16'h0010, 16'h0000, 0);   // R7 register cleared

    // constrained random
    for (int i = 0; i < 300; i++) begin
      int k;
      int p;
      int s;
      logic [15:0] a;
      logic [15:0] d;
      k = $urandom % 10;
      p = $urandom % 4;
      s = 2 + ($urandom % 8);
      set_cfg(p, s);
      a = ($urandom % 2) ? 16'($urandom % 16) : 16'(8'hF0 + ($urandom % 16));
      d = 16'($urandom % 256);
      if (k == 0)      run_op(1, 0, a, d, 0);
      else if (k == 1) begin
        if ($urandom % 2) run_op(0, $urandom % 2, a | 16'h0100, d, 0);
        else              run_op(0, 1, a, d | 16'h0200, 0);
      end
      else run_op(0, k < 6, a, d, ($urandom % 8) == 0);
    end
    finish_run();
  end

endmodule